// File: doc/BRIEF.md
# SPI Parameter Receiver with Stretched Completion Flag

This block is an SPI slave that takes one transaction from a microcontroller and turns it into two parallel bytes: a parameter number and that parameter's current value. The master holds a load line high for the length of the transaction. The serial clock, data and load lines are brought into the fast system clock through two-flop synchronizers. Data bits are shifted in on rising serial-clock edges while load is high.

When load falls, both bytes are copied to the outputs in the same cycle, and a completion flag goes high. The flag stays high for a fixed number of fast cycles. That count equals the ratio between the fast clock and a 20 kHz control clock, so the slow domain always samples the flag at least once. If another transaction ends while the flag is still high, the hold count restarts and the flag stays high without a gap.

Top module: `spi_param_rx`

## Requirements
- R1: A synchronous active-high reset sets `param_out`, `value_out` and `done` to 0.
- R2: While the synchronized load is high, each rising serial-clock edge shifts in one `mosi` bit, most significant bit first. Of a 16-bit transaction, the first 8 bits form the parameter byte and the last 8 bits form the value byte.
- R3: `param_out` and `value_out` change only at the end of a transaction, and both change in the same cycle. During a transaction they keep their previous values.
- R4: The end of a transaction is the falling edge of `load`. The new bytes and a high `done` appear after the third rising clock edge that follows the fall: two synchronizer stages plus one register.
- R5: After an isolated transaction, `done` stays high for exactly `HOLD_CYCLES` clock cycles and then goes low.
- R6: If a transaction ends while `done` is high, the hold count restarts. `done` stays high without a gap. Its total width is the number of cycles between the two load falls plus `HOLD_CYCLES`.
- R7: Serial-clock edges while `load` is low change neither output byte and produce no `done` pulse.
- R8: The shift register is cleared when `load` rises. A transaction with fewer than 16 bits therefore presents the 16-bit word whose low bits are the received bits and whose upper bits are 0. With 8 bits, `param_out` is 0 and `value_out` holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| load | input | 1 | High while a transaction is in progress (asynchronous) |
| param_out | output | FIELD_W | Parameter number byte from the last completed transaction |
| value_out | output | FIELD_W | Parameter value byte from the last completed transaction |
| done | output | 1 | Completion flag, held high for HOLD_CYCLES cycles |

## Verification
The bench builds the block with `FIELD_W` = 8 and `HOLD_CYCLES` = 300 rather than 1000. A full 16-bit transaction at the bench's serial-clock rate takes roughly 140 fast cycles. At a hold of 300 cycles, a second transaction can therefore end while the first flag is still high, which exercises the restart case. The hold is still short enough that many random transactions, each timed to the exact width, fit in the run. Random bytes are mixed with directed cases: all-zero and all-one words, a short 8-bit transfer, and serial-clock activity with load low.

// File: rtl/spi_param_rx.sv
module spi_param_rx #(
  parameter int FIELD_W     = 8,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               mosi,
  input  logic               load,
  output logic [FIELD_W-1:0] param_out,
  output logic [FIELD_W-1:0] value_out,
  output logic               done
);

  localparam int WORD_W = 2 * FIELD_W;
  localparam int CNT_W  = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_HOLD} st_t;

  logic [2:0]        sck_s, load_s;
  logic [1:0]        mosi_s;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  st_t               state;

  wire sck_rise  = sck_s[1] & ~sck_s[2];
  wire load_rise = load_s[1] & ~load_s[2];
  wire load_fall = ~load_s[1] & load_s[2];
  wire bit_in    = mosi_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s  <= '0;
      load_s <= '0;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      load_s <= {load_s[1:0], load};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      shreg <= '0;
    else if (load_rise)
      shreg <= '0;
    else if (load_s[1] && sck_rise)
      shreg <= {shreg[WORD_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      param_out <= '0;
      value_out <= '0;
    end else if (load_fall) begin
      param_out <= shreg[WORD_W-1:FIELD_W];
      value_out <= shreg[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (load_fall) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else if (state == ST_HOLD) begin
      if (cnt == LAST) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done = (state == ST_HOLD);

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (load_s[1] && sck_rise && !load_rise) |=> shreg[0] == $past(bit_in));

  // R3
  pair_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_fall |=> ($stable(param_out) && $stable(value_out)));

  // R4
  end_latch_chk: assert property (@(posedge clk) disable iff (rst)
    load_fall |=> (done && {param_out, value_out} == $past(shreg)));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cnt != LAST) |=> done);

  // R5
  hold_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cnt == LAST && !load_fall) |=> !done);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done && load_fall) |=> (done && cnt == '0));

endmodule

// File: tb/tb_spi_param_rx.sv
module tb_spi_param_rx;
  localparam int CLK_P = 10;
  localparam int FW    = 8;
  localparam int HOLD  = 300;
  localparam int HALF  = 4;

  logic clk = 0, rst = 1, sck = 0, mosi = 0, load = 0;
  logic [FW-1:0] param_out, value_out;
  logic done;

  int total = 0, bad = 0;
  int cyc = 0, rise_cyc = 0, fall_cyc = 0, rises = 0;
  logic prev_done = 0;
  logic [FW-1:0] exp_p = 0, exp_v = 0;
  bit finished = 0;

  spi_param_rx #(.FIELD_W(FW), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .load(load),
    .param_out(param_out), .value_out(value_out), .done(done));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (done && !prev_done) begin rise_cyc = cyc; rises++; end
    if (!done && prev_done) fall_cyc = cyc;
    prev_done = done;
  end

  function automatic logic [FW-1:0] hi_of(input logic [2*FW-1:0] w);
    return w[2*FW-1:FW];
  endfunction
  function automatic logic [FW-1:0] lo_of(input logic [2*FW-1:0] w);
    return w[FW-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shifts out w[nbits-1:0] MSB first; leaves load high at the end (caller drops it)
  task automatic shift_word(input logic [2*FW-1:0] w, input int nbits);
    load = 1;
    waitc(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = w[i];
      sck = 0; waitc(HALF);
      sck = 1; waitc(HALF);
      if (i == nbits / 2) begin
        chk("R3 mid param", param_out, exp_p);
        chk("R3 mid value", value_out, exp_v);
      end
    end
    sck = 0;
    waitc(HALF);
  endtask

  // Drop load at a negedge, check latency and bytes; returns cycle of the fall
  task automatic finish_xfer(input logic [2*FW-1:0] w, input bit was_done, output int t_fall);
    load = 0;
    t_fall = cyc;
    @(posedge clk); @(posedge clk); #1;
    if (!was_done) chk("R4 done not yet", done, 0);
    chk("R4 bytes not yet", {param_out, value_out}, {exp_p, exp_v});
    @(posedge clk); #1;
    exp_p = hi_of(w);
    exp_v = lo_of(w);
    chk("R4 done at third edge", done, 1);
    chk("R2 param byte", param_out, exp_p);
    chk("R2 value byte", value_out, exp_v);
  endtask

  task automatic wait_idle();
    while (done) @(negedge clk);
    waitc(3);
  endtask

  task automatic single(input logic [2*FW-1:0] w);
    int tf, r0;
    r0 = rises;
    shift_word(w, 2*FW);
    finish_xfer(w, 0, tf);
    wait_idle();
    chk("R5 width", fall_cyc - rise_cyc, HOLD);
    chk("R5 one pulse", rises - r0, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tf1, tf2, r0;
    logic [2*FW-1:0] w, w2;
    void'($urandom(32'd2024));
    waitc(5);
    chk("R1 param reset", param_out, 0);
    chk("R1 value reset", value_out, 0);
    chk("R1 done reset", done, 0);
    rst = 0;
    waitc(5);

    single(16'hA53C);
    single(16'h0000);
    single(16'hFFFF);
    for (int k = 0; k < 6; k++) single(16'($urandom));

    // R7: sck activity with load low
    r0 = rises;
    for (int i = 0; i < 2*FW; i++) begin
      mosi = ~mosi; sck = 1; waitc(HALF); sck = 0; waitc(HALF);
    end
    waitc(6);
    chk("R7 param kept", param_out, exp_p);
    chk("R7 value kept", value_out, exp_v);
    chk("R7 no done", rises - r0, 0);
    chk("R7 done low", done, 0);

    // R8: short 8-bit transfer after a full one loaded the register
    w = {8'h00, 8'($urandom) | 8'h81};
    shift_word(w, 8);
    finish_xfer(w, 0, tf1);
    chk("R8 short param zero", param_out, 0);
    wait_idle();

    // R6: second transaction ends while done is still high
    r0 = rises;
    w  = 16'($urandom);
    w2 = 16'($urandom) ^ 16'h5A5A;
    shift_word(w, 2*FW);
    finish_xfer(w, 0, tf1);
    shift_word(w2, 2*FW);
    chk("R6 done held during second", done, 1);
    finish_xfer(w2, 1, tf2);
    wait_idle();
    chk("R6 single pulse", rises - r0, 1);
    chk("R6 stretched width", fall_cyc - rise_cyc, (tf2 - tf1) + HOLD);

    // R1: reset after activity
    shift_word(16'h1234, 2*FW);
    finish_xfer(16'h1234, 0, tf1);
    rst = 1;
    waitc(2);
    chk("R1 param cleared", param_out, 0);
    chk("R1 value cleared", value_out, 0);
    chk("R1 done cleared", done, 0);
    load = 0;
    rst = 0;
    exp_p = 0; exp_v = 0;
    waitc(5);
    single(16'($urandom));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule